// File: doc/BRIEF.md
# PTP Timestamp Capture Queue

This block sits beside one direction of an Ethernet port, either transmit or receive. A design that handles both directions uses two copies, and each copy has its own address range. The block records the time at which each precision-time event frame passes the port. When a frame delimiter goes by, the block latches the current clock value, given as 48-bit seconds and 32-bit nanoseconds. The record is committed only after the frame parser reports that the frame is a PTP event message. The committed record is 128 bits. It holds the latched time together with the parser's message type, checksum field and sequence number. Records go into a small queue that is written in the Ethernet clock domain and read in the CPU clock domain.

The CPU polls the queue from its own clock domain. It raises a read request and waits for an acknowledge, and it then takes the record from the read data port. The record leaves the queue only after the request drops, which shows that the transfer is complete. A status word gives the number of records held and a sticky overflow flag. Reading status clears the flag. A flush strobe empties the queue.

Two state machines do the work. The capture machine runs in the Ethernet domain and has the states CAP_IDLE, CAP_ARMED and CAP_DONE:
- A start-of-frame moves it from any state to CAP_ARMED and latches the time.
- In CAP_ARMED, an event flag moves it to CAP_DONE and commits the record, or drops the record when the queue is full.
- In CAP_ARMED or CAP_DONE, end-of-frame moves it back to CAP_IDLE.

The reader machine runs in the CPU domain and has the states RD_IDLE, RD_HELD and RD_VOID:
- In RD_IDLE, a request moves it to RD_HELD when a record is waiting. It moves to RD_VOID instead when the queue is empty or a flush arrives in the same cycle.
- In RD_HELD, a flush moves it to RD_VOID, and a dropped request moves it to RD_IDLE and pops the record.
- In RD_VOID, a dropped request moves it to RD_IDLE.

Top module: `ts_capture_queue`

## Requirements
- R1: A record is laid out as follows: bits [127:112] are zero, [111:64] seconds, [63:32] nanoseconds, [31:28] message type, [27:16] checksum field and [15:0] sequence number.
- R2: The seconds and nanoseconds in a record are the clock values sampled in the cycle in which `sof` is high. Later clock values never enter the record.
- R3: A record is committed only when `ptp_event` is high in a cycle after the `sof` cycle and no later than the `eof` cycle. An event in the same cycle as `eof` still counts. The type, checksum and sequence fields are sampled in that event cycle, and a frame with no event adds nothing.
- R4: A frame commits at most one record. An event flag that repeats in later cycles of the same frame is ignored.
- R5: The queue holds at most 15 records. A frame classified while 15 are held is discarded, and the stored records are unchanged.
- R6: A discarded frame sets the overflow flag, `q_status[4]`. A cycle with `stat_rd` high clears the flag. When a new drop notice arrives in the same cycle as `stat_rd`, the flag stays set, and a clear that happens before the notice arrives does not hide the drop.
- R7: `q_status[3:0]` gives the number of records held. It follows writes within a few CPU cycles.
- R8: After `rd_req` rises on a non-empty queue, `rd_ack` goes high with `rd_data` equal to the oldest record. Data and acknowledge hold while `rd_req` stays high. The record is removed, and `rd_ack` falls, only after `rd_req` falls, so records come out in arrival order.
- R9: A request made while the queue is empty is acknowledged with all-zero `rd_data` and removes nothing.
- R10: A pulse on `flush` discards every held record. When `flush` falls in the same cycle as `rd_req`, the flush wins and no extra pop happens.
- R11: After reset, `rd_ack` is 0, `rd_data` is zero and `q_status` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| eth_clk | input | 1 | Ethernet-side clock |
| cpu_clk | input | 1 | CPU-side clock |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| sof | input | 1 | Frame start; clock value latched this cycle |
| eof | input | 1 | Last cycle of the frame |
| ptp_event | input | 1 | Parser says this frame is a PTP event message |
| msg_kind | input | 4 | Message type from the parser |
| csum_fld | input | 12 | Checksum field from the parser |
| seq_id | input | 16 | Sequence number from the parser |
| rtc_sec | input | 48 | Current time, seconds |
| rtc_nsec | input | 32 | Current time, nanoseconds |
| rd_req | input | 1 | CPU read request (level) |
| rd_ack | output | 1 | Read acknowledge |
| rd_data | output | 128 | Record handed to the CPU |
| stat_rd | input | 1 | Status read strobe; clears overflow |
| flush | input | 1 | Empty the queue |
| q_status | output | 5 | {overflow, record count} |

## Verification
Two pairs of actions can fall in the same CPU cycle.

The first pair is a pop and a flush. The bench holds a record under acknowledge and then drops `rd_req` in the same cycle that `flush` is high. It then expects a count of zero, and it expects the next frame to come back intact rather than a stale or skipped slot.

The second pair is a status read and an incoming drop notice. The bench fills the queue and pulses `stat_rd` while a further frame is being discarded, before the notice can cross domains, and it expects the flag to remain set. The exact-cycle collision is judged by the `p_set_wins_r6` property.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    localparam int REC_W = 128;

    typedef enum logic [1:0] {CAP_IDLE, CAP_ARMED, CAP_DONE} cap_state_e;
    typedef enum logic [1:0] {RD_IDLE, RD_HELD, RD_VOID} rd_state_e;

    typedef struct packed {
        logic [15:0] pad;
        logic [47:0] sec;
        logic [31:0] nsec;
        logic [3:0]  kind;
        logic [11:0] csum;
        logic [15:0] seq;
    } ts_rec_t;

endpackage

// File: rtl/tsq_sync.sv
module tsq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/tsq_store.sv
module tsq_store #(
    parameter int AW = 4,
    parameter int DW = 128
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [DW-1:0] mem [ENTRIES];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tsq_capture.sv
module tsq_capture
    import tsq_pkg::*;
#(
    parameter int AW    = 4,
    parameter int DEPTH = 15
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             sof,
    input  logic             eof,
    input  logic             ptp_event,
    input  logic [3:0]       msg_kind,
    input  logic [11:0]      csum_fld,
    input  logic [15:0]      seq_id,
    input  logic [47:0]      rtc_sec,
    input  logic [31:0]      rtc_nsec,
    input  logic [AW:0]      rptr_gray_s,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [REC_W-1:0] wr_rec,
    output logic [AW:0]      wptr_gray,
    output logic             drop_tgl
);
    localparam int PW = AW + 1;

    cap_state_e    st, st_nx;
    logic [PW-1:0] wbin, wnext, rbin_s, used;
    logic [47:0]   sec_l;
    logic [31:0]   nsec_l;
    logic          classify, full, drop_now;
    ts_rec_t       rec;

    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign rbin_s[i] = ^(rptr_gray_s >> i);
    end

    assign used  = wbin - rbin_s;
    assign full  = (used >= PW'(DEPTH));
    assign wnext = wbin + PW'(1);

    always_comb begin
        st_nx = st;
        unique case (st)
            CAP_IDLE:  if (sof) st_nx = CAP_ARMED;
            CAP_ARMED: begin
                if (sof)            st_nx = CAP_ARMED;
                else if (ptp_event) st_nx = CAP_DONE;
                else if (eof)       st_nx = CAP_IDLE;
            end
            CAP_DONE: begin
                if (sof)      st_nx = CAP_ARMED;
                else if (eof) st_nx = CAP_IDLE;
            end
            default: st_nx = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st <= CAP_IDLE;
        else         st <= st_nx;
    end

    always_comb begin
        classify = (st == CAP_ARMED) && ptp_event && !sof;
        wr_en    = classify && !full;
        drop_now = classify && full;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sec_l     <= '0;
            nsec_l    <= '0;
            wbin      <= '0;
            wptr_gray <= '0;
            drop_tgl  <= 1'b0;
        end else begin
            if (sof) begin
                sec_l  <= rtc_sec;
                nsec_l <= rtc_nsec;
            end
            if (wr_en) begin
                wbin      <= wnext;
                wptr_gray <= wnext ^ (wnext >> 1);
            end
            if (drop_now) drop_tgl <= ~drop_tgl;
        end
    end

    assign rec = '{pad: 16'h0, sec: sec_l, nsec: nsec_l,
                   kind: msg_kind, csum: csum_fld, seq: seq_id};
    assign wr_rec  = rec;
    assign wr_addr = wbin[AW-1:0];

    // R4: a commit is never followed by another in the next cycle
    p_single_commit_r4: assert property (@(posedge clk) disable iff (!arst_n)
        wr_en |=> !wr_en);

    // R5: the write side never sees more than DEPTH records outstanding
    p_depth_r5: assert property (@(posedge clk) disable iff (!arst_n)
        used <= PW'(DEPTH));
endmodule

// File: rtl/tsq_reader.sv
module tsq_reader
    import tsq_pkg::*;
#(
    parameter int AW    = 4,
    parameter int DEPTH = 15
) (
    input  logic                     clk,
    input  logic                     arst_n,
    input  logic                     rd_req,
    input  logic                     stat_rd,
    input  logic                     flush,
    input  logic [AW:0]              wptr_gray_s,
    input  logic                     drop_tgl_s,
    input  logic [REC_W-1:0]         rd_word,
    output logic [AW-1:0]            rd_addr,
    output logic [AW:0]              rptr_gray,
    output logic                     rd_ack,
    output logic [REC_W-1:0]         rd_data,
    output logic [$clog2(DEPTH+1):0] status
);
    localparam int PW = AW + 1;
    localparam int CW = $clog2(DEPTH + 1);

    rd_state_e     st, st_nx;
    logic [PW-1:0] rbin, wbin_s, used, rnext;
    logic          empty, pop, load, drop_prev, drop_seen, ovf;

    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign wbin_s[i] = ^(wptr_gray_s >> i);
    end

    assign used      = wbin_s - rbin;
    assign empty     = (used == '0);
    assign drop_seen = drop_tgl_s ^ drop_prev;
    assign rnext     = flush ? wbin_s : rbin + PW'(1);

    always_comb begin
        st_nx = st;
        unique case (st)
            RD_IDLE: if (rd_req) st_nx = (empty || flush) ? RD_VOID : RD_HELD;
            RD_HELD: begin
                if (flush)       st_nx = RD_VOID;
                else if (!rd_req) st_nx = RD_IDLE;
            end
            RD_VOID: if (!rd_req) st_nx = RD_IDLE;
            default: st_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st <= RD_IDLE;
        else         st <= st_nx;
    end

    always_comb begin
        rd_ack = (st != RD_IDLE);
        pop    = (st == RD_HELD) && !rd_req && !flush;
        load   = (st == RD_IDLE) && rd_req;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            rbin      <= '0;
            rptr_gray <= '0;
            rd_data   <= '0;
            drop_prev <= 1'b0;
            ovf       <= 1'b0;
        end else begin
            if (flush || pop) begin
                rbin      <= rnext;
                rptr_gray <= rnext ^ (rnext >> 1);
            end
            if (load) rd_data <= (empty || flush) ? '0 : rd_word;
            drop_prev <= drop_tgl_s;
            if (drop_seen)    ovf <= 1'b1;
            else if (stat_rd) ovf <= 1'b0;
        end
    end

    assign rd_addr = rbin[AW-1:0];
    assign status  = {ovf, used[CW-1:0]};

    // R8: acknowledge stays up while the request is held
    p_ack_hold_r8: assert property (@(posedge clk) disable iff (!arst_n)
        (rd_ack && rd_req) |=> rd_ack);

    // R8: handed-over data does not move during the handshake
    p_data_stable_r8: assert property (@(posedge clk) disable iff (!arst_n)
        (rd_ack && rd_req) |=> $stable(rd_data));

    // R8: no acknowledge appears without a request
    p_no_spurious_ack_r8: assert property (@(posedge clk) disable iff (!arst_n)
        (!rd_req && !rd_ack) |=> !rd_ack);

    // R5: the read side never counts more than DEPTH records
    p_count_cap_r5: assert property (@(posedge clk) disable iff (!arst_n)
        used <= PW'(DEPTH));

    // R6: a drop notice sets the flag even when status is read in that cycle
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!arst_n)
        drop_seen |=> status[CW]);
endmodule

// File: rtl/ts_capture_queue.sv
module ts_capture_queue
    import tsq_pkg::*;
#(
    parameter int AW    = 4,
    parameter int DEPTH = 15
) (
    input  logic                     eth_clk,
    input  logic                     cpu_clk,
    input  logic                     arst_n,
    input  logic                     sof,
    input  logic                     eof,
    input  logic                     ptp_event,
    input  logic [3:0]               msg_kind,
    input  logic [11:0]              csum_fld,
    input  logic [15:0]              seq_id,
    input  logic [47:0]              rtc_sec,
    input  logic [31:0]              rtc_nsec,
    input  logic                     rd_req,
    output logic                     rd_ack,
    output logic [REC_W-1:0]         rd_data,
    input  logic                     stat_rd,
    input  logic                     flush,
    output logic [$clog2(DEPTH+1):0] q_status
);
    localparam int PW = AW + 1;

    logic             wr_en, drop_tgl, drop_tgl_s;
    logic [AW-1:0]    wr_addr, rd_addr;
    logic [REC_W-1:0] wr_rec, rd_word;
    logic [PW-1:0]    wptr_gray, wptr_gray_s, rptr_gray, rptr_gray_s;

    tsq_capture #(.AW(AW), .DEPTH(DEPTH)) u_cap (
        .clk(eth_clk), .arst_n(arst_n), .sof(sof), .eof(eof),
        .ptp_event(ptp_event), .msg_kind(msg_kind), .csum_fld(csum_fld),
        .seq_id(seq_id), .rtc_sec(rtc_sec), .rtc_nsec(rtc_nsec),
        .rptr_gray_s(rptr_gray_s), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_rec(wr_rec), .wptr_gray(wptr_gray), .drop_tgl(drop_tgl)
    );

    tsq_store #(.AW(AW), .DW(REC_W)) u_store (
        .wclk(eth_clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_rec),
        .raddr(rd_addr), .rdata(rd_word)
    );

    tsq_sync #(.W(PW)) u_sync_w (
        .clk(cpu_clk), .arst_n(arst_n), .d(wptr_gray), .q(wptr_gray_s));

    tsq_sync #(.W(1)) u_sync_drop (
        .clk(cpu_clk), .arst_n(arst_n), .d(drop_tgl), .q(drop_tgl_s));

    tsq_sync #(.W(PW)) u_sync_r (
        .clk(eth_clk), .arst_n(arst_n), .d(rptr_gray), .q(rptr_gray_s));

    tsq_reader #(.AW(AW), .DEPTH(DEPTH)) u_rd (
        .clk(cpu_clk), .arst_n(arst_n), .rd_req(rd_req), .stat_rd(stat_rd),
        .flush(flush), .wptr_gray_s(wptr_gray_s), .drop_tgl_s(drop_tgl_s),
        .rd_word(rd_word), .rd_addr(rd_addr), .rptr_gray(rptr_gray),
        .rd_ack(rd_ack), .rd_data(rd_data), .status(q_status)
    );
endmodule

// File: tb/ts_capture_queue_test.sv
module ts_capture_queue_test;
    localparam int CW  = 4;
    localparam int CAP = 15;

    logic         eth_clk = 0, cpu_clk = 0, arst_n = 0;
    logic         sof = 0, eof = 0, ptp_event = 0;
    logic [3:0]   msg_kind = 0;
    logic [11:0]  csum_fld = 0;
    logic [15:0]  seq_id = 0;
    logic [47:0]  rtc_sec = 48'h0000_1000_0000;
    logic [31:0]  rtc_nsec = 0;
    logic         rd_req = 0, stat_rd = 0, flush = 0;
    logic         rd_ack;
    logic [127:0] rd_data;
    logic [CW:0]  q_status;

    int checks = 0, errors = 0, fidx = 0;
    logic [127:0] model[$];

    always #2 eth_clk = ~eth_clk;
    always #5 cpu_clk = ~cpu_clk;
    always @(posedge eth_clk) rtc_nsec <= rtc_nsec + 32'd7;

    ts_capture_queue uut (
        .eth_clk(eth_clk), .cpu_clk(cpu_clk), .arst_n(arst_n), .sof(sof),
        .eof(eof), .ptp_event(ptp_event), .msg_kind(msg_kind),
        .csum_fld(csum_fld), .seq_id(seq_id), .rtc_sec(rtc_sec),
        .rtc_nsec(rtc_nsec), .rd_req(rd_req), .rd_ack(rd_ack),
        .rd_data(rd_data), .stat_rd(stat_rd), .flush(flush),
        .q_status(q_status)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one frame: event 'gap' cycles after sof, optionally on the eof cycle, optionally repeated
    task automatic frame(input int gap, input bit ev, input bit same_eof, input bit dbl);
        logic [3:0]   k = fidx[3:0];
        logic [11:0]  c = 12'h5A0 + fidx[11:0];
        logic [15:0]  s = 16'hC000 + fidx[15:0];
        logic [127:0] rec;
        fidx++;
        @(negedge eth_clk);
        sof = 1; rtc_sec = rtc_sec + 48'h1_0001;
        msg_kind = ~k; csum_fld = ~c; seq_id = ~s;
        rec = {16'h0, rtc_sec, rtc_nsec, k, c, s};
        @(negedge eth_clk);
        sof = 0; rtc_sec = rtc_sec + 48'h1;
        for (int i = 1; i < gap; i++) @(negedge eth_clk);
        ptp_event = ev; msg_kind = k; csum_fld = c; seq_id = s; eof = same_eof;
        @(negedge eth_clk);
        eof = 0;
        if (dbl) begin
            msg_kind = ~k; seq_id = ~s;
            @(negedge eth_clk);
        end
        ptp_event = 0; msg_kind = ~k;
        if (!same_eof) begin
            eof = 1;
            @(negedge eth_clk);
            eof = 0;
        end
        repeat (3) @(negedge eth_clk);
        if (ev && model.size() < CAP) model.push_back(rec);
    endtask

    task automatic settle();
        repeat (6) @(negedge cpu_clk);
    endtask

    task automatic pulse_stat();
        @(negedge cpu_clk); stat_rd = 1;
        @(negedge cpu_clk); stat_rd = 0;
    endtask

    task automatic read_and_check(input string tag, input logic [127:0] exp, input int held);
        int w = 0;
        @(negedge cpu_clk); rd_req = 1;
        while (!rd_ack && w < 40) begin @(negedge cpu_clk); w++; end
        check("R8 acknowledge raised", 128'(rd_ack), 128'd1);
        check(tag, rd_data, exp);
        repeat (2) @(negedge cpu_clk);
        check("R8 data held while request high", rd_data, exp);
        check("R8 no pop before release", 128'(q_status[CW-1:0]), 128'(held));
        rd_req = 0;
        w = 0;
        while (rd_ack && w < 40) begin @(negedge cpu_clk); w++; end
        check("R8 acknowledge released", 128'(rd_ack), 128'd0);
    endtask

    task automatic drain(input string tag);
        while (model.size() > 0) begin
            read_and_check(tag, model[0], model.size());
            void'(model.pop_front());
        end
        @(negedge cpu_clk);
        check("R8 count after drain", 128'(q_status[CW-1:0]), 128'd0);
    endtask

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge cpu_clk);
        arst_n = 1;
        @(negedge cpu_clk);
        check("R11 rd_ack after reset", 128'(rd_ack), 128'd0);
        check("R11 rd_data after reset", rd_data, 128'd0);
        check("R11 q_status after reset", 128'(q_status), 128'd0);

        // R9: empty read
        read_and_check("R9 empty read data", 128'd0, 0);

        // R1 R2 R3 R4: sweep event position, eof alignment and presence
        for (int g = 1; g <= 3; g++)
            for (int e = 0; e <= 1; e++)
                for (int same = 0; same <= 1; same++)
                    frame(g, e[0], same[0], 1'b0);
        frame(2, 1'b1, 1'b0, 1'b1);   // repeated event flag, R4
        settle();
        check("R7 count after sweep", 128'(q_status[CW-1:0]), 128'(model.size()));
        check("R6 no overflow yet", 128'(q_status[CW]), 128'd0);
        drain("R1 R2 R3 R4 record contents");

        // R5 R6: fill past capacity
        for (int n = 0; n < CAP + 2; n++) frame(2, 1'b1, 1'b0, 1'b0);
        settle();
        check("R5 count at capacity", 128'(q_status[CW-1:0]), 128'(CAP));
        check("R6 overflow flag set", 128'(q_status[CW]), 128'd1);
        pulse_stat();
        @(negedge cpu_clk);
        check("R6 overflow cleared by status read", 128'(q_status[CW]), 128'd0);
        check("R7 count unchanged by status read", 128'(q_status[CW-1:0]), 128'(CAP));
        drain("R5 stored records untouched by drops");

        // R10: plain flush
        for (int n = 0; n < 3; n++) frame(1, 1'b1, 1'b1, 1'b0);
        settle();
        check("R7 count before flush", 128'(q_status[CW-1:0]), 128'd3);
        @(negedge cpu_clk); flush = 1;
        @(negedge cpu_clk); flush = 0;
        check("R10 count after flush", 128'(q_status[CW-1:0]), 128'd0);
        model.delete();
        read_and_check("R10 read after flush is empty", 128'd0, 0);

        // R10: flush in the same cycle as request release
        frame(2, 1'b1, 1'b0, 1'b0);
        frame(3, 1'b1, 1'b0, 1'b0);
        settle();
        @(negedge cpu_clk); rd_req = 1;
        repeat (2) @(negedge cpu_clk);
        check("R8 held record before flush", rd_data, model[0]);
        rd_req = 0; flush = 1;
        @(negedge cpu_clk); flush = 0;
        repeat (3) @(negedge cpu_clk);
        check("R10 ack released after flush", 128'(rd_ack), 128'd0);
        check("R10 flush wins over pop", 128'(q_status[CW-1:0]), 128'd0);
        model.delete();
        frame(1, 1'b1, 1'b0, 1'b0);
        settle();
        drain("R10 record after flush and pop");

        // R6: status read lands before the drop notice crosses over
        for (int n = 0; n < CAP; n++) frame(1, 1'b1, 1'b0, 1'b0);
        settle();
        check("R6 flag clear before extra frame", 128'(q_status[CW]), 128'd0);
        fork
            frame(3, 1'b1, 1'b0, 1'b0);
            pulse_stat();
        join
        settle();
        check("R6 drop survives earlier status read", 128'(q_status[CW]), 128'd1);
        check("R5 count still at capacity", 128'(q_status[CW-1:0]), 128'(CAP));
        pulse_stat();
        @(negedge cpu_clk);
        check("R6 flag cleared afterwards", 128'(q_status[CW]), 128'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule